// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block is the memory half of a serial slave that also serves a parallel port. A bus front end decodes the wire protocol and hands this controller single-cycle events: start, repeated start, stop, a match on the memory identity together with the direction bit, a received byte, and the master's acknowledge or not-acknowledge after a byte the slave has sent. The controller answers with an acknowledge pulse for address matches and for received bytes, and it presents the next byte to be shifted out on reads.

The storage is a 256-entry byte array held as a register file. Incoming write data is first collected in a 16-entry page buffer. The array is updated only when a stop ends the write. A down-counter then models the self-timed programming cycle. While that counter runs, the memory identity is not acknowledged, so a master can poll for completion. A single address pointer serves both reads and writes. The pointer moves only within the current 16-byte page during writes, and it wraps across the whole array during reads.

Top module: `eeprom_txn_ctrl`

## Requirements
- R1: After reset `busy`, `addr_ack` and `byte_ack` are low, `tx_byte` is 0x00, the address pointer is 0, and every array location reads 0xFF.
- R2: An address match with `busy` low yields `addr_ack` high for the one cycle after the event. In a write session, the first received byte is the word address and each later byte is data. Every received byte of a write session yields `byte_ack` high for the one cycle after it.
- R3: A word address, one data byte and a stop store that byte at that address. After the write, the pointer holds the address plus one.
- R4: During a write, only the low 4 pointer bits advance after each data byte. Byte 17 and later wrap to the start of the page and overwrite earlier buffered bytes.
- R5: The array changes only on a stop that follows at least one data byte, and only at the buffered offsets. A start or repeated start before the stop discards the buffered data. Neighbouring locations keep their values.
- R6: A committing stop raises `busy` in the next cycle, and `busy` stays high for exactly WR_CYCLES cycles.
- R7: While `busy` is high, an address match of either direction is not acknowledged. It also leaves the pointer unchanged.
- R8: A read address match with no address phase loads `tx_byte` with the byte at the pointer and advances the pointer by one.
- R9: A write session that ends after the word address with no data (a dummy write) only loads the pointer and starts no write cycle. A repeated start and a read match then return the byte at that address.
- R10: Each master acknowledge in a read loads `tx_byte` with the byte at the pointer and advances the pointer. The pointer wraps from 0xFF to 0x00.
- R11: A master not-acknowledge ends the read. A later master acknowledge without a new read match changes neither `tx_byte` nor the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition seen |
| ev_rstart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_addr | input | 1 | Memory identity matched |
| addr_rd | input | 1 | Direction bit with ev_addr, 1 = read |
| ev_byte | input | 1 | Byte received from master |
| rx_byte | input | 8 | Received byte value |
| ev_mack | input | 1 | Master acknowledged a sent byte |
| ev_mnack | input | 1 | Master did not acknowledge a sent byte |
| addr_ack | output | 1 | Acknowledge for the address match |
| byte_ack | output | 1 | Acknowledge for the received byte |
| tx_byte | output | 8 | Byte to send next on a read |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The checker assumes that the front end delivers at most one event per cycle, and it asserts this on the event inputs. It also assumes that an address match always follows a start or a repeated start. The directed tests pulse each event for exactly one cycle, on the falling clock edge, in legal protocol order. The only deliberately stray events are address matches sent while busy and a master acknowledge sent after a not-acknowledge. Both are legal single events that the design must ignore.

// File: rtl/eeprom_txn_pkg.sv
package eeprom_txn_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WADDR = 2'd1,
      ST_WDATA = 2'd2,
      ST_READ  = 2'd3
   } sess_e;
endpackage

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic                              we,
   input  logic [PAGE_W-1:0]                 idx,
   input  logic [DATA_W-1:0]                 din,
   output logic [(1<<PAGE_W)*DATA_W-1:0]     data,
   output logic [(1<<PAGE_W)-1:0]            mask
);
   localparam int PAGE_LEN = 1 << PAGE_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data <= '0;
         mask <= '0;
      end else if (clr) begin
         mask <= '0;
      end else if (we) begin
         data[idx*DATA_W +: DATA_W] <= din;
         mask[idx]                  <= 1'b1;
      end
   end

   if (PAGE_LEN < 2) begin : g_bad_page
      $error("page buffer needs at least two entries");
   end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              commit,
   input  logic [ADDR_W-PAGE_W-1:0]          page,
   input  logic [(1<<PAGE_W)*DATA_W-1:0]     wdata,
   input  logic [(1<<PAGE_W)-1:0]            wmask,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_data
);
   localparam int DEPTH    = 1 << ADDR_W;
   localparam int PAGE_LEN = 1 << PAGE_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (commit) begin
         for (int j = 0; j < PAGE_LEN; j++)
            if (wmask[j]) mem[{page, PAGE_W'(j)}] <= wdata[j*DATA_W +: DATA_W];
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
   parameter int WR_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(WR_CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CNT_W'(WR_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   if (WR_CYCLES < 1) begin : g_bad_len
      $error("write cycle length must be at least one clock");
   end
endmodule

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_rstart,
   input  logic              ev_stop,
   input  logic              ev_addr,
   input  logic              addr_rd,
   input  logic              ev_byte,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              ev_mack,
   input  logic              ev_mnack,
   output logic              addr_ack,
   output logic              byte_ack,
   output logic [DATA_W-1:0] tx_byte,
   output logic              busy
);
   import eeprom_txn_pkg::*;

   localparam int PAGE_LEN = 1 << PAGE_W;
   localparam int PG_IDX_W = ADDR_W - PAGE_W;

   sess_e                        state;
   logic [ADDR_W-1:0]            ptr;
   logic [DATA_W-1:0]            rd_data;
   logic [PAGE_LEN*DATA_W-1:0]   pb_data;
   logic [PAGE_LEN-1:0]          pb_mask;
   logic                         pb_we, pb_clr, commit;

   assign pb_we  = ev_byte && (state == ST_WDATA);
   assign pb_clr = ev_start || ev_rstart || ev_stop;
   assign commit = ev_stop && (state == ST_WDATA) && (pb_mask != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ptr      <= '0;
         tx_byte  <= '0;
         addr_ack <= 1'b0;
         byte_ack <= 1'b0;
      end else begin
         addr_ack <= 1'b0;
         byte_ack <= 1'b0;
         if (ev_start || ev_rstart || ev_stop) begin
            state <= ST_IDLE;
         end else if (ev_addr) begin
            if (busy) begin
               state <= ST_IDLE;
            end else begin
               addr_ack <= 1'b1;
               if (addr_rd) begin
                  state   <= ST_READ;
                  tx_byte <= rd_data;
                  ptr     <= ptr + 1'b1;
               end else begin
                  state <= ST_WADDR;
               end
            end
         end else if (ev_byte) begin
            if (state == ST_WADDR) begin
               ptr      <= rx_byte[ADDR_W-1:0];
               state    <= ST_WDATA;
               byte_ack <= 1'b1;
            end else if (state == ST_WDATA) begin
               ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
               byte_ack        <= 1'b1;
            end
         end else if (ev_mack && state == ST_READ) begin
            tx_byte <= rd_data;
            ptr     <= ptr + 1'b1;
         end else if (ev_mnack && state == ST_READ) begin
            state <= ST_IDLE;
         end
      end
   end

   eeprom_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_pbuf (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (pb_clr),
      .we   (pb_we),
      .idx  (ptr[PAGE_W-1:0]),
      .din  (rx_byte),
      .data (pb_data),
      .mask (pb_mask)
   );

   eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_arr (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .page   (ptr[ADDR_W-1:PAGE_W]),
      .wdata  (pb_data),
      .wmask  (pb_mask),
      .rd_addr(ptr),
      .rd_data(rd_data)
   );

   eeprom_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(commit),
      .busy (busy)
   );

   if (PAGE_W >= ADDR_W || PG_IDX_W < 1) begin : g_bad_geom
      $error("page must be smaller than the array");
   end
   if (DATA_W < ADDR_W) begin : g_bad_width
      $error("data byte must be wide enough to carry a word address");
   end
endmodule

// File: rtl/eeprom_txn_chk.sv
module eeprom_txn_chk #(
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_start,
   input logic              ev_rstart,
   input logic              ev_stop,
   input logic              ev_addr,
   input logic              ev_byte,
   input logic              ev_mack,
   input logic              ev_mnack,
   input logic              addr_ack,
   input logic              byte_ack,
   input logic [DATA_W-1:0] tx_byte,
   input logic              busy
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1;
      else           run_cnt <= '0;
   end

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_start, ev_rstart, ev_stop, ev_addr, ev_byte, ev_mack, ev_mnack}));
   AST_ACK_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr && !busy) |=> addr_ack); // R2
   AST_NO_BYTE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_byte |=> !byte_ack); // R2
   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr && busy) |=> !addr_ack); // R7
   AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ev_stop)); // R5
   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run_cnt != 0) |-> (run_cnt == WR_CYCLES)); // R6
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ev_addr) && !$past(ev_mack)) |-> $stable(tx_byte)); // R10
endmodule

bind eeprom_txn_ctrl eeprom_txn_chk #(.DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
   .ev_stop(ev_stop), .ev_addr(ev_addr), .ev_byte(ev_byte), .ev_mack(ev_mack),
   .ev_mnack(ev_mnack), .addr_ack(addr_ack), .byte_ack(byte_ack),
   .tx_byte(tx_byte), .busy(busy)
);

// File: tb/eeprom_txn_ctrl_bench.sv
module eeprom_txn_ctrl_bench;
   localparam int WR = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr = 0, addr_rd = 0;
   logic       ev_byte = 0, ev_mack = 0, ev_mnack = 0;
   logic [7:0] rx_byte = '0;
   logic       addr_ack, byte_ack, busy;
   logic [7:0] tx_byte;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   eeprom_txn_ctrl #(.WR_CYCLES(WR)) u_eeprom_txn_ctrl (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
      .ev_stop(ev_stop), .ev_addr(ev_addr), .addr_rd(addr_rd), .ev_byte(ev_byte),
      .rx_byte(rx_byte), .ev_mack(ev_mack), .ev_mnack(ev_mnack),
      .addr_ack(addr_ack), .byte_ack(byte_ack), .tx_byte(tx_byte), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic p_start();  @(negedge clk) ev_start = 1;  @(negedge clk) ev_start = 0;  endtask
   task automatic p_rstart(); @(negedge clk) ev_rstart = 1; @(negedge clk) ev_rstart = 0; endtask
   task automatic p_stop();   @(negedge clk) ev_stop = 1;   @(negedge clk) ev_stop = 0;   endtask
   task automatic p_mack();   @(negedge clk) ev_mack = 1;   @(negedge clk) ev_mack = 0;   endtask
   task automatic p_mnack();  @(negedge clk) ev_mnack = 1;  @(negedge clk) ev_mnack = 0;  endtask

   task automatic p_addr(input bit rd, output bit ack);
      @(negedge clk) begin ev_addr = 1; addr_rd = rd; end
      @(negedge clk) ev_addr = 0;
      ack = addr_ack;
   endtask

   task automatic p_byte(input logic [7:0] b, output bit ack);
      @(negedge clk) begin ev_byte = 1; rx_byte = b; end
      @(negedge clk) ev_byte = 0;
      ack = byte_ack;
   endtask

   task automatic wait_ready();
      while (busy) @(negedge clk);
   endtask

   task automatic write_seq(input logic [7:0] a, input logic [7:0] d[], input string req);
      bit ack;
      p_start();
      p_addr(0, ack);
      check(ack, req, ack, 1);
      p_byte(a, ack);
      check(ack, req, ack, 1);
      foreach (d[k]) begin
         p_byte(d[k], ack);
         if (!ack) check(0, req, ack, 1);
      end
      p_stop();
   endtask

   task automatic rand_read(input logic [7:0] a, output logic [7:0] q);
      bit ack;
      p_start();
      p_addr(0, ack);
      p_byte(a, ack);
      p_rstart();
      p_addr(1, ack);
      q = tx_byte;
   endtask

   task automatic t_reset();
      bit ack;
      check(busy == 0 && addr_ack == 0 && byte_ack == 0, "R1", {busy, addr_ack, byte_ack}, 0);
      check(tx_byte == 8'h00, "R1", tx_byte, 8'h00);
      p_start();
      p_addr(1, ack);
      check(tx_byte == 8'hFF, "R1 erased at pointer 0", tx_byte, 8'hFF);
      p_stop();
   endtask

   task automatic t_byte_write();
      logic [7:0] q;
      write_seq(8'h25, '{8'hA5}, "R2");
      wait_ready();
      rand_read(8'h25, q);
      check(q == 8'hA5, "R3", q, 8'hA5);
      p_mack();
      check(tx_byte == 8'hFF, "R5 neighbour untouched", tx_byte, 8'hFF);
      p_stop();
   endtask

   task automatic t_busy();
      bit ack;
      int n = 0;
      write_seq(8'h40, '{8'h11}, "R3");
      check(busy == 1, "R6 busy after stop", busy, 1);
      p_start();
      p_addr(1, ack);
      check(ack == 0, "R7 read lockout", ack, 0);
      p_start();
      p_addr(0, ack);
      check(ack == 0, "R7 write lockout", ack, 0);
      p_stop();
      wait_ready();
      p_start();
      p_addr(1, ack);
      check(tx_byte == 8'hFF, "R7/R8 pointer at 0x41", tx_byte, 8'hFF);
      p_stop();
      // measure the cycle length separately
      write_seq(8'h41, '{8'h22}, "R6");
      while (busy) begin n++; @(negedge clk); end
      check(n == WR, "R6 busy length", n, WR);
      p_start();
      p_addr(1, ack);
      check(tx_byte == 8'hFF, "R8 current read at 0x42", tx_byte, 8'hFF);
      p_stop();
   endtask

   task automatic t_page();
      logic [7:0] d[] = new[18];
      logic [7:0] q, e;
      foreach (d[k]) d[k] = 8'h80 + 8'(k);
      write_seq(8'h3E, d, "R4");
      wait_ready();
      rand_read(8'h30, q);
      for (int j = 0; j < 16; j++) begin
         if (j > 0) begin p_mack(); q = tx_byte; end
         e = (j < 14) ? 8'(8'h82 + j) : ((j == 14) ? 8'h90 : 8'h91);
         check(q == e, "R4 page wrap", q, e);
      end
      p_mnack();
      p_stop();
   endtask

   task automatic t_discard();
      bit ack;
      logic [7:0] q;
      p_start();
      p_addr(0, ack);
      p_byte(8'h50, ack);
      p_byte(8'h77, ack);
      p_start();
      check(busy == 0, "R5 no cycle without stop", busy, 0);
      p_stop();
      rand_read(8'h50, q);
      check(q == 8'hFF, "R5 discarded", q, 8'hFF);
      check(busy == 0, "R9 dummy write no cycle", busy, 0);
      p_stop();
   endtask

   task automatic t_seq_nack();
      logic [7:0] q;
      bit ack;
      write_seq(8'h00, '{8'hC3, 8'hD4, 8'hE5}, "R4");
      wait_ready();
      write_seq(8'hFF, '{8'h5A}, "R3");
      wait_ready();
      rand_read(8'hFF, q);
      check(q == 8'h5A, "R9 random read", q, 8'h5A);
      p_mack();
      check(tx_byte == 8'hC3, "R10 wrap to 0", tx_byte, 8'hC3);
      p_mack();
      check(tx_byte == 8'hD4, "R10 next", tx_byte, 8'hD4);
      p_mnack();
      p_mack();
      check(tx_byte == 8'hD4, "R11 mack after nack", tx_byte, 8'hD4);
      p_stop();
      p_start();
      p_addr(1, ack);
      check(tx_byte == 8'hE5, "R11 pointer held", tx_byte, 8'hE5);
      p_stop();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_byte_write();
      t_busy();
      t_page();
      t_discard();
      t_seq_nack();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule